// File: doc/BRIEF.md
# UART Interrupt Status Unit

This block collects the interrupt sources of a serial port and presents them to software through a small register set. It watches the live fill levels of the receive and transmit FIFOs and compares each against a programmable threshold. It also takes a one-cycle pulse from a line-break detector. Each source has its own two-state event machine. That machine latches a pending condition until software clears it. A single interrupt line goes high whenever a pending source is also enabled.

Software reads the raw pending bits, or reads them already masked by the enable register. It acknowledges a source by writing a one to that source's position in the clear register. The receive source fires when the receive count reaches its threshold. The transmit source fires when the transmit count falls to its threshold. The count width is a parameter, so one block serves a narrow (8-bit) and a wide (10-bit) counter build. The transmit threshold field always starts at the bit just above the receive threshold.

Each source runs the same machine. It has two states, EV_IDLE and EV_PENDING. It moves from EV_IDLE to EV_PENDING in any cycle where its set condition is true. It moves back from EV_PENDING to EV_IDLE only in a cycle where its clear bit is written and its set condition is false. In every other cycle it keeps its state.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the enable register reads 0 and `irq` is 0. The receive and break pending bits are 0. The threshold register (byte offset 0x24) reads receive threshold 1 and transmit threshold 0.
- R2: Bit 0 of the raw register (offset 0x04) becomes 1 one cycle after the receive count is at or above the receive threshold. The bit then stays 1 until it is cleared in a cycle where the condition is false.
- R3: Bit 1 of the raw register becomes 1 one cycle after the transmit count is at or below the transmit threshold. The bit then stays 1 until it is cleared in a cycle where the condition is false.
- R4: A one-cycle pulse on `brk_pulse` sets raw bit 7 on the next cycle. The bit stays set until it is cleared.
- R5: Writing the clear register (offset 0x10) clears each raw bit that is written as 1. Bits written as 0 are left as they are. A threshold source whose condition still holds stays set after the clear.
- R6: When a set condition and a clear of the same source land in one cycle, the source ends up pending.
- R7: The enable register (offset 0x0C) keeps only bits 0, 1 and 7 and reads back with all other bits 0. The status register (offset 0x08) reads as the raw bits ANDed with the enable bits.
- R8: `irq` is 1 exactly when some status bit is 1. Writing 0 to the enable register forces `irq` to 0.
- R9: The count register (offset 0x1C) shows the receive count from bit 0 and the transmit count from bit 16. Each count is CNT_W bits wide.
- R10: The threshold register holds the receive threshold from bit 0 and the transmit threshold from bit CNT_W. It reads back what was written.
- R11: The clear register and unmapped offsets read 0. Writes to the raw and status registers have no effect.
- R12: `reg_rdata` is loaded on the clock edge where `reg_rd` is 1. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| rx_level | input | CNT_W | Receive FIFO fill count |
| tx_level | input | CNT_W | Transmit FIFO fill count |
| brk_pulse | input | 1 | One-cycle line-break event |
| irq | output | 1 | Interrupt request |

## Verification
The bench clears a threshold source while its condition still holds. A design that dropped the bit there would lose an event that software expects to see again. The bench also clears the break bit in the same cycle that a new break arrives. A clear-wins design would lose that second break. The bench drops the counts back below threshold before clearing, to show the pending state is sticky rather than a copy of the comparator. It also shows that irq follows only the enabled sources, so a masked pending bit cannot raise the line. Finally it writes to read-only offsets and leaves the read strobe idle, to catch a design that corrupts state or lets the read data drift.

// File: rtl/uisr_pkg.sv
package uisr_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SRC_N  = 3;

    localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ENA  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_THR  = 8'h24;

    typedef enum logic {
        EV_IDLE    = 1'b0,
        EV_PENDING = 1'b1
    } ev_state_e;

    typedef enum logic {
        CMP_AT_OR_ABOVE = 1'b0,
        CMP_AT_OR_BELOW = 1'b1
    } cmp_kind_e;

    // source index -> register bit: 0 receive level, 1 transmit level, 2 break
    function automatic int unsigned src_pos(input int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 7;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SRC_N; i++) begin
            m[src_pos(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/uisr_thresh_cmp.sv
module uisr_thresh_cmp
    import uisr_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter cmp_kind_e   KIND  = CMP_AT_OR_ABOVE
) (
    input  logic [CNT_W-1:0] level_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             hit_o
);

    generate
        if (KIND == CMP_AT_OR_ABOVE) begin : g_ge
            always_comb hit_o = (level_i >= thresh_i);
        end else begin : g_le
            always_comb hit_o = (level_i <= thresh_i);
        end
    endgenerate

endmodule

// File: rtl/uisr_event_fsm.sv
module uisr_event_fsm
    import uisr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    ev_state_e state_q;
    ev_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: begin
                if (set_i) state_d = EV_PENDING;
            end
            EV_PENDING: begin
                if (clr_i && !set_i) state_d = EV_IDLE;
            end
            default: state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == EV_PENDING);
    end

endmodule

// File: rtl/uisr_regfile.sv
module uisr_regfile
    import uisr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] en_word,
    output logic [DATA_W-1:0] clr_word,
    output logic [CNT_W-1:0]  rx_thr,
    output logic [CNT_W-1:0]  tx_thr
);

    localparam logic [DATA_W-1:0] MASK    = src_mask();
    localparam int unsigned       PAD_CNT = 16 - CNT_W;
    localparam int unsigned       PAD_THR = DATA_W - 2 * CNT_W;
    localparam int unsigned       TXT_LSB = CNT_W;

    logic [DATA_W-1:0] rd_word;
    logic              hit_ena;
    logic              hit_clr;
    logic              hit_thr;

    always_comb begin
        hit_ena = wr_en && (addr == OFF_ENA);
        hit_clr = wr_en && (addr == OFF_CLR);
        hit_thr = wr_en && (addr == OFF_THR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_word <= '0;
            rx_thr  <= CNT_W'(1);
            tx_thr  <= '0;
        end else begin
            if (hit_ena) en_word <= wdata & MASK;
            if (hit_thr) begin
                rx_thr <= wdata[CNT_W-1:0];
                tx_thr <= wdata[TXT_LSB +: CNT_W];
            end
        end
    end

    always_comb begin
        clr_word = hit_clr ? (wdata & MASK) : '0;
    end

    always_comb begin
        unique case (addr)
            OFF_RAW:  rd_word = raw_word;
            OFF_STAT: rd_word = raw_word & en_word;
            OFF_ENA:  rd_word = en_word;
            OFF_CNT:  rd_word = {{PAD_CNT{1'b0}}, tx_level, {PAD_CNT{1'b0}}, rx_level};
            OFF_THR:  rd_word = {{PAD_THR{1'b0}}, tx_thr, rx_thr};
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uisr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic              brk_pulse,
    output logic              irq
);

    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] en_word;
    logic [DATA_W-1:0] clr_word;
    logic [CNT_W-1:0]  rx_thr;
    logic [CNT_W-1:0]  tx_thr;
    logic              rx_hit;
    logic              tx_hit;
    logic [SRC_N-1:0]  set_src;
    logic [SRC_N-1:0]  clr_src;
    logic [SRC_N-1:0]  pend_src;

    uisr_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .raw_word (raw_word),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rdata    (reg_rdata),
        .en_word  (en_word),
        .clr_word (clr_word),
        .rx_thr   (rx_thr),
        .tx_thr   (tx_thr)
    );

    uisr_thresh_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_OR_ABOVE)) u_rx_cmp (
        .level_i  (rx_level),
        .thresh_i (rx_thr),
        .hit_o    (rx_hit)
    );

    uisr_thresh_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_OR_BELOW)) u_tx_cmp (
        .level_i  (tx_level),
        .thresh_i (tx_thr),
        .hit_o    (tx_hit)
    );

    always_comb begin
        set_src = {brk_pulse, tx_hit, rx_hit};
        for (int unsigned i = 0; i < SRC_N; i++) begin
            clr_src[i] = clr_word[src_pos(i)];
        end
    end

    generate
        for (genvar g = 0; g < SRC_N; g++) begin : g_src
            uisr_event_fsm u_ev (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_src[g]),
                .clr_i  (clr_src[g]),
                .pend_o (pend_src[g])
            );
        end
    endgenerate

    always_comb begin
        raw_word = '0;
        for (int unsigned i = 0; i < SRC_N; i++) begin
            raw_word[src_pos(i)] = pend_src[i];
        end
    end

    always_comb begin
        irq = |(raw_word & en_word);
    end

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [31:0]      reg_rdata,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             brk_pulse,
    input logic             irq,
    input logic [CNT_W-1:0] rx_thr,
    input logic [CNT_W-1:0] tx_thr,
    input logic [31:0]      en_word,
    input logic [31:0]      clr_word,
    input logic [2:0]       pend_src
);

    assert_rx_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= rx_thr) |=> pend_src[0]);

    assert_tx_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_thr) |=> pend_src[1]);

    assert_break_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_src[2] && !clr_word[7]) |=> pend_src[2]);

    assert_break_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> pend_src[2]);

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_word[7] && !brk_pulse) |=> !pend_src[2]);

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_word[7] && brk_pulse) |=> pend_src[2]);

    assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_word == 32'h0) |-> !irq);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind uart_irq_unit uart_irq_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .brk_pulse (brk_pulse),
    .irq       (irq),
    .rx_thr    (rx_thr),
    .tx_thr    (tx_thr),
    .en_word   (en_word),
    .clr_word  (clr_word),
    .pend_src  (pend_src)
);

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;

    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] tx_level = '0;
    logic             brk_pulse = 1'b0;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_unit #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_level(rx_level), .tx_level(tx_level), .brk_pulse(brk_pulse), .irq(irq)
    );

    // monitor: a read strobe taken at one edge yields data checked at the next falling edge
    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_rd = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic levels(input int r, input int t);
        rx_level = CNT_W'(r);
        tx_level = CNT_W'(t);
        @(negedge clk);
    endtask

    task automatic brk();
        brk_pulse = 1'b1;
        @(negedge clk);
        brk_pulse = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state (tx level 0 <= tx threshold 0, so only bit 1 is pending)
        chk({31'b0, irq}, 32'h0, "R1 irq after reset");
        rd(8'h0C, 32'h0, "R1 enable after reset");
        rd(8'h04, 32'h2, "R1 raw after reset");
        rd(8'h24, 32'h1, "R1 thresholds after reset");
        // R10: thresholds rx=8 at bit 0, tx=2 at bit 8
        wr(8'h24, 32'h0000_0208);
        rd(8'h24, 32'h0000_0208, "R10 threshold readback");
        // R9: counts
        levels(5, 3);
        rd(8'h1C, 32'h0003_0005, "R9 count word");
        levels(200, 17);
        rd(8'h1C, 32'h0011_00C8, "R9 count word second pattern");
        levels(5, 3);
        wr(8'h10, 32'h0000_0083);
        rd(8'h04, 32'h0, "R5 clear all with conditions false");
        // R2
        levels(8, 3);
        rd(8'h04, 32'h1, "R2 rx at threshold");
        levels(7, 3);
        rd(8'h04, 32'h1, "R2 rx sticky below threshold");
        wr(8'h10, 32'h1);
        rd(8'h04, 32'h0, "R5 rx clear");
        levels(9, 3);
        wr(8'h10, 32'h1);
        rd(8'h04, 32'h1, "R5 rx re-asserts while condition holds");
        // R3
        levels(9, 2);
        rd(8'h04, 32'h3, "R3 tx at threshold");
        levels(9, 10);
        wr(8'h10, 32'h2);
        rd(8'h04, 32'h1, "R5 tx clear");
        wr(8'h10, 32'h0);
        rd(8'h04, 32'h1, "R5 zero write leaves bits");
        // R4
        brk();
        rd(8'h04, 32'h81, "R4 break sets");
        repeat (4) @(negedge clk);
        rd(8'h04, 32'h81, "R4 break sticky");
        // R7, R8
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h83, "R7 enable keeps source bits only");
        rd(8'h08, 32'h81, "R7 status masked");
        chk({31'b0, irq}, 32'h1, "R8 irq with all enabled");
        wr(8'h0C, 32'h0);
        chk({31'b0, irq}, 32'h0, "R8 irq masked by zero enable");
        rd(8'h08, 32'h0, "R7 status with zero enable");
        wr(8'h0C, 32'h80);
        chk({31'b0, irq}, 32'h1, "R8 irq from break only");
        wr(8'h10, 32'h80);
        chk({31'b0, irq}, 32'h0, "R8 irq drops after break clear, rx masked");
        rd(8'h08, 32'h0, "R7 status after break clear");
        // R6: pulse and clear in the same cycle
        brk_pulse = 1'b1;
        wr(8'h10, 32'h80);
        brk_pulse = 1'b0;
        rd(8'h04, 32'h81, "R6 set beats clear");
        // R11
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);
        rd(8'h04, 32'h81, "R11 raw write ignored");
        rd(8'h10, 32'h0, "R11 clear reads zero");
        rd(8'h30, 32'h0, "R11 unmapped reads zero");
        // R12: data holds without a read strobe
        levels(1, 1);
        brk();
        wr(8'h10, 32'h83);
        repeat (3) @(negedge clk);
        chk(reg_rdata, 32'h0, "R12 rdata holds without strobe");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule